// File: doc/BRIEF.md
# Sixteen-Pin Configurable I/O Bank

This block controls sixteen pad-facing pins from a byte-wide register port. Each pin is set by software as an input or an output. Input pins are synchronised to the block clock. Each input can optionally be inverted, and each can add to a shared level-sensitive interrupt request. Output pins can drive a programmed value in push-pull fashion, pull low only (open drain), or release the pad completely so that another driver can share the line.

Pin 0 has one extra role. While an external timer asserts its routing input, pin 0 is driven continuously by the timer's output level. During that time every setting the registers hold for pin 0 is bypassed. When the routing input drops, the stored settings take effect again. Pad cells, the timer and host bus bridging sit outside the block. The block presents per-pin output enable and output value toward the pads, and it takes the raw pad levels back in.

Top module: `pinbank_top`

## Requirements
- R1: Bit n of the direction register selects the role of pin n: 1 = output, 0 = input. An input pin (not taken by the timer) holds pad_oe and pad_out at 0.
- R2: Pad levels pass through two clocked stages. A pad change applied before rising edge k is visible on irq and in level readback only after edge k+1.
- R3: Bit n of the invert register set to 1 inverts the synchronised level of input pin n before readback and before interrupt evaluation. The effect is combinational with respect to the register.
- R4: An output pin whose three-state bit is 1 has pad_oe = 0 and pad_out = 0, whatever its level and open-drain bits hold.
- R5: An output pin with open drain set and three-state clear drives pad_oe = 1, pad_out = 0 when its level bit is 0. When its level bit is 1 it gives pad_oe = 0, pad_out = 0.
- R6: An output pin with both three-state and open drain clear drives pad_oe = 1 and pad_out = its level bit.
- R7: irq is high exactly when at least one pin is an input (not taken by the timer), has its interrupt-enable bit set, and has a post-inversion level of 1. Output pins never contribute.
- R8: While tmr_route is 1, pad_oe[0] = 1, pad_out[0] = tmr_level, readback bit 0 of the level register equals tmr_level, and pin 0 adds nothing to irq, whatever the registers hold.
- R9: reg_addr[3:1] selects the register: 0 interrupt enable, 1 level, 2 three-state, 3 invert, 4 direction, 5 open drain. reg_addr[0] = 0 selects pins 7..0, and 1 selects pins 15..8. reg_rdata follows reg_addr combinationally. A write with reg_wen lands at the next rising edge and changes only the addressed byte. Addresses 12 to 15 read 0 and ignore writes.
- R10: A level register read returns the synchronised post-inversion pad level for input pins and the last written value for output pins.
- R11: After reset all six registers read 0, pad_oe and pad_out are 0 on every pin, and irq is 0 (tmr_route low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 4 | Byte address: register slot and half |
| reg_wen | input | 1 | Write strobe for the addressed byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pad_in | input | 16 | Raw levels from the pads |
| pad_oe | output | 16 | Per-pin output enable toward the pads |
| pad_out | output | 16 | Per-pin driven value toward the pads |
| tmr_route | input | 1 | Hands pin 0 to the timer while high |
| tmr_level | input | 1 | Timer output level for pin 0 |
| irq | output | 1 | Combined pin interrupt request |

## Verification
All pin settings are static state, so a corrupted register bit shows up at once. It appears on pad_oe or pad_out in the next cycle, and it reads back through reg_rdata with no delay. A fault in the synchroniser shows only as a timing error: irq and level readback move one edge early or late. The bench therefore samples between edges around a pad change. A fault in the pin-0 bypass shows only while tmr_route toggles. The bench flips it with pin 0 configured in ways that would otherwise drive, float or interrupt.

// File: rtl/pinbank_pkg.sv
`timescale 1ns/1ps
package pinbank_pkg;

    localparam int NPINS  = 16;
    localparam int BYTE_W = 8;
    localparam int HALVES = NPINS / BYTE_W;
    localparam int NREGS  = 6;
    localparam int SLOT_W = 3;
    localparam int ADDR_W = SLOT_W + $clog2(HALVES);
    localparam int BSH    = $clog2(BYTE_W);

    typedef logic [NPINS-1:0] pins_t;

    typedef enum logic [SLOT_W-1:0] {
        RG_IEN = 3'd0,
        RG_LVL = 3'd1,
        RG_HIZ = 3'd2,
        RG_INV = 3'd3,
        RG_DIR = 3'd4,
        RG_OD  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        pins_t ien;
        pins_t lvl;
        pins_t hiz;
        pins_t inv;
        pins_t dir;
        pins_t od;
    } bank_cfg_t;

    typedef struct packed {
        logic ien;
        logic lvl;
        logic hiz;
        logic inv;
        logic dir;
        logic od;
    } pin_cfg_t;

    function automatic pin_cfg_t slice_cfg(bank_cfg_t c, int idx);
        pin_cfg_t p;
        p.ien = c.ien[idx];
        p.lvl = c.lvl[idx];
        p.hiz = c.hiz[idx];
        p.inv = c.inv[idx];
        p.dir = c.dir[idx];
        p.od  = c.od[idx];
        return p;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
`timescale 1ns/1ps
module pinbank_sync #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [DEPTH-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < DEPTH; k++) begin
                stg[k] <= stg[k-1];
            end
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/pinbank_regs.sv
`timescale 1ns/1ps
module pinbank_regs
    import pinbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wen,
    input  logic [BYTE_W-1:0] wdata,
    input  pins_t             lvl_view,
    output logic [BYTE_W-1:0] rdata,
    output bank_cfg_t         cfg
);
    logic [SLOT_W-1:0]             slot;
    logic                          half;
    logic                          slot_ok;
    logic [NREGS-1:0][NPINS-1:0]   bank_q;
    pins_t                         word;

    assign slot    = addr[ADDR_W-1:1];
    assign half    = addr[0];
    assign slot_ok = (int'(slot) < NREGS);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (wen && slot_ok) begin
            bank_q[slot][{half, {BSH{1'b0}}} +: BYTE_W] <= wdata;
        end
    end

    assign cfg.ien = bank_q[RG_IEN];
    assign cfg.lvl = bank_q[RG_LVL];
    assign cfg.hiz = bank_q[RG_HIZ];
    assign cfg.inv = bank_q[RG_INV];
    assign cfg.dir = bank_q[RG_DIR];
    assign cfg.od  = bank_q[RG_OD];

    always_comb begin
        word = '0;
        if (slot_ok) begin
            if (slot == RG_LVL) word = lvl_view;
            else                word = bank_q[slot];
        end
        rdata = word[{half, {BSH{1'b0}}} +: BYTE_W];
    end
endmodule

// File: rtl/pinbank_pin.sv
`timescale 1ns/1ps
module pinbank_pin
    import pinbank_pkg::*;
#(
    parameter bit TIMER_CAP = 1'b0
) (
    input  pin_cfg_t cfg,
    input  logic     syncd,
    input  logic     t_route,
    input  logic     t_val,
    output logic     oe,
    output logic     out,
    output logic     view,
    output logic     irq_bit
);
    logic tsel;
    logic level_in;

    assign tsel     = TIMER_CAP ? t_route : 1'b0;
    assign level_in = syncd ^ cfg.inv;

    always_comb begin
        oe      = 1'b0;
        out     = 1'b0;
        view    = level_in;
        irq_bit = 1'b0;
        if (tsel) begin
            oe   = 1'b1;
            out  = t_val;
            view = t_val;
        end else if (cfg.dir) begin
            view = cfg.lvl;
            if (cfg.hiz) begin
                oe = 1'b0;
            end else if (cfg.od) begin
                oe = ~cfg.lvl;
            end else begin
                oe  = 1'b1;
                out = cfg.lvl;
            end
        end else begin
            irq_bit = cfg.ien & level_in;
        end
    end
endmodule

// File: rtl/pinbank_top.sv
`timescale 1ns/1ps
module pinbank_top
    import pinbank_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wen,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [15:0] pad_in,
    output logic [15:0] pad_oe,
    output logic [15:0] pad_out,
    input  logic        tmr_route,
    input  logic        tmr_level,
    output logic        irq
);
    bank_cfg_t cfg;
    pins_t     pad_s;
    pins_t     lvl_view;
    pins_t     pin_irq;

    pinbank_sync #(.W(NPINS), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_s)
    );

    pinbank_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (reg_addr),
        .wen      (reg_wen),
        .wdata    (reg_wdata),
        .lvl_view (lvl_view),
        .rdata    (reg_rdata),
        .cfg      (cfg)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_cfg_t pc;
        assign pc = slice_cfg(cfg, i);
        if (i == 0) begin : g_tmr
            pinbank_pin #(.TIMER_CAP(1'b1)) u_pin (
                .cfg     (pc),
                .syncd   (pad_s[i]),
                .t_route (tmr_route),
                .t_val   (tmr_level),
                .oe      (pad_oe[i]),
                .out     (pad_out[i]),
                .view    (lvl_view[i]),
                .irq_bit (pin_irq[i])
            );
        end else begin : g_std
            pinbank_pin #(.TIMER_CAP(1'b0)) u_pin (
                .cfg     (pc),
                .syncd   (pad_s[i]),
                .t_route (1'b0),
                .t_val   (1'b0),
                .oe      (pad_oe[i]),
                .out     (pad_out[i]),
                .view    (lvl_view[i]),
                .irq_bit (pin_irq[i])
            );
        end
    end

    assign irq = |pin_irq;
endmodule

// File: rtl/pinbank_chk.sv
`timescale 1ns/1ps
module pinbank_chk (
    input logic        clk,
    input logic        rst,
    input logic        tmr_route,
    input logic        tmr_level,
    input logic [15:0] pad_oe,
    input logic [15:0] pad_out,
    input logic        irq,
    input logic [15:0] cfg_ien,
    input logic [15:0] cfg_lvl,
    input logic [15:0] cfg_hiz,
    input logic [15:0] cfg_dir,
    input logic [15:0] cfg_od
);
    logic [15:0] own;
    assign own = ~{15'b0, tmr_route};

    p_input_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ((~cfg_dir & own & pad_oe) == 16'h0));

    p_hiz_release_r4: assert property (@(posedge clk) disable iff (rst)
        ((cfg_dir & cfg_hiz & own & pad_oe) == 16'h0));

    p_od_no_high_r5: assert property (@(posedge clk) disable iff (rst)
        ((cfg_dir & cfg_od & cfg_lvl & own & pad_oe) == 16'h0));

    p_od_no_value_r5: assert property (@(posedge clk) disable iff (rst)
        ((cfg_dir & cfg_od & own & pad_out) == 16'h0));

    p_irq_source_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((cfg_ien & ~cfg_dir & own) != 16'h0));

    p_timer_pin0_r8: assert property (@(posedge clk) disable iff (rst)
        tmr_route |-> (pad_oe[0] && (pad_out[0] == tmr_level)));
endmodule

bind pinbank_top pinbank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tmr_route (tmr_route),
    .tmr_level (tmr_level),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .irq       (irq),
    .cfg_ien   (cfg.ien),
    .cfg_lvl   (cfg.lvl),
    .cfg_hiz   (cfg.hiz),
    .cfg_dir   (cfg.dir),
    .cfg_od    (cfg.od)
);

// File: tb/sim_pinbank_top.sv
`timescale 1ns/1ps
module sim_pinbank_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_oe;
    logic [15:0] pad_out;
    logic        tmr_route = 1'b0;
    logic        tmr_level = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 rdata, 1 pad_oe, 2 pad_out, 3 irq
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #5 clk = ~clk;

    pinbank_top u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .tmr_route(tmr_route),
        .tmr_level(tmr_level), .irq(irq)
    );

    // monitor: pops expected items between edges and compares
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            logic [15:0] got;
            it = sbq.pop_front();
            case (it.kind)
                0:       got = {8'h00, reg_rdata};
                1:       got = pad_oe;
                2:       got = pad_out;
                default: got = {15'h0, irq};
            endcase
            checks++;
            if (got !== it.exp) begin
                failures++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, got, it.exp);
            end
        end
    end

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(posedge clk);
        #1;
        reg_wen   = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] base, input logic [15:0] v);
        wr(base, v[7:0]);
        wr(base + 4'd1, v[15:8]);
    endtask

    task automatic expect_item(input int kind, input logic [15:0] e, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = e;
        it.tag  = tag;
        sbq.push_back(it);
        settle();
    endtask

    task automatic chk_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        reg_addr = a;
        #1;
        expect_item(0, {8'h00, e}, tag);
    endtask

    task automatic wait_sync();
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        #500000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        settle();

        // R11 reset state, R9 map reads 0
        expect_item(1, 16'h0000, "R11 oe");
        expect_item(2, 16'h0000, "R11 out");
        expect_item(3, 16'h0000, "R11 irq");
        for (int a = 0; a < 16; a++) chk_rd(4'(a), 8'h00, "R11 R9 reg");

        // R1 R6 push-pull outputs on pins 7..0
        wr16(4'd8, 16'h00FF);
        wr16(4'd2, 16'hA5C3);
        expect_item(1, 16'h00FF, "R1 R6 oe");
        expect_item(2, 16'h00C3, "R1 R6 out");

        // R10 readback mix, R2 after sync
        pad_in = 16'h3C00;
        wait_sync();
        chk_rd(4'd2, 8'hC3, "R10 out view");
        chk_rd(4'd3, 8'h3C, "R10 in view");
        expect_item(3, 16'h0000, "R7 no enable");

        // R3 inversion of upper inputs
        wr(4'd7, 8'hFF);
        chk_rd(4'd3, 8'hC3, "R3 inverted view");
        chk_rd(4'd7, 8'hFF, "R9 inv readback");

        // R7 interrupt sourcing
        wr16(4'd0, 16'h0100);
        expect_item(3, 16'h0001, "R7 pin8 inv high");
        wr16(4'd0, 16'h0400);
        expect_item(3, 16'h0000, "R7 pin10 inv low");
        wr16(4'd0, 16'h0001);
        expect_item(3, 16'h0000, "R7 output pin ignored");
        wr(4'd7, 8'h00);
        wr16(4'd0, 16'h0400);
        expect_item(3, 16'h0001, "R7 pin10 plain high");

        // R2 two-edge latency
        @(posedge clk);
        #1;
        pad_in = 16'h3800;
        expect_item(3, 16'h0001, "R2 before edge1");
        expect_item(3, 16'h0001, "R2 after edge1");
        expect_item(3, 16'h0000, "R2 after edge2");

        // R4 R5 open drain and three-state on upper pins
        wr(4'd9, 8'hFF);
        wr(4'd11, 8'hFF);
        wr(4'd5, 8'hF0);
        expect_item(1, 16'h0AFF, "R4 R5 oe");
        expect_item(2, 16'h00C3, "R4 R5 out");
        chk_rd(4'd3, 8'hA5, "R10 upper outputs");
        expect_item(3, 16'h0000, "R7 now output");

        // R8 timer override of pin 0
        wr(4'd8, 8'hFE);
        wr16(4'd0, 16'h0001);
        pad_in = 16'h3801;
        tmr_level = 1'b0;
        tmr_route = 1'b1;
        wait_sync();
        expect_item(3, 16'h0000, "R8 irq masked");
        expect_item(1, 16'h0AFF, "R8 oe pin0");
        expect_item(2, 16'h00C2, "R8 out low");
        chk_rd(4'd2, 8'hC2, "R8 view low");
        tmr_level = 1'b1;
        #1;
        expect_item(2, 16'h00C3, "R8 out high");
        chk_rd(4'd2, 8'hC3, "R8 view high");
        tmr_route = 1'b0;
        #1;
        expect_item(3, 16'h0001, "R8 released irq");
        expect_item(1, 16'h0AFE, "R8 released oe");
        expect_item(2, 16'h00C2, "R8 released out");

        // R9 unused slots and byte isolation
        wr(4'd12, 8'hFF);
        wr(4'd15, 8'hFF);
        chk_rd(4'd12, 8'h00, "R9 slot6 lo");
        chk_rd(4'd15, 8'h00, "R9 slot7 hi");
        wr(4'd9, 8'h00);
        chk_rd(4'd8, 8'hFE, "R9 low byte kept");
        chk_rd(4'd9, 8'h00, "R9 high byte");
        expect_item(1, 16'h00FE, "R1 upper inputs");

        settle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule